// File: doc/BRIEF.md
# Alternate Sweep Display Selector

This block decides, for each display cycle, whether the main (A) sweep or the delayed (B) sweep drives the horizontal channel. A two-bit mode input selects one of three behaviours. The block can stay on A, stay on B, or alternate between them. The end of each sweep is signalled by a falling edge on the alternate-sync line. The block samples that line on the system clock and detects the edge synchronously.

With plain alternation, the selection flips at every end of sweep. When the vertical system is also alternating between two channels, the block keeps its own channel-select bit, which flips at every end of sweep. The sweep selection then advances only when that bit returns to channel 1. The display order is therefore A on channel 1, A on channel 2, B on channel 1, then B on channel 2, and the cycle repeats. An active-low separation enable goes low only while alternation is active and B is shown.

Top module: `alt_sweep_selector`

## Requirements
- R1: With `hmode` = 2'b00 (and the unused code 2'b11, which behaves the same), the clock edge after it is seen leaves `a_disp`=1 and `b_disp`=0, whatever `alt_sync` and `dual_alt` do.
- R2: With `hmode` = 2'b01, the clock edge after it is seen leaves `b_disp`=1 and `a_disp`=0, and falls of `alt_sync` do not change it.
- R3: With `hmode` = 2'b10 and `dual_alt`=0, an end of sweep inverts the selection at that edge. An end of sweep is `alt_sync` sampled 1 on one clock edge and 0 on the next.
- R4: With `hmode` = 2'b10 and `dual_alt`=1, `ch1_sel` (1 = channel 1) inverts at each end of sweep.
- R5: With `hmode` = 2'b10 and `dual_alt`=1, the selection inverts only at an end of sweep that moves `ch1_sel` from 0 to 1. The resulting order is A ch1, A ch2, B ch1, B ch2.
- R6: `sep_n` is 0 only while the registered mode is 2'b10 and B is selected; it is 1 otherwise.
- R7: The first edge at which `hmode` is 2'b10 after another mode selects A and sets `ch1_sel`=1. This takes priority over an end of sweep at the same edge.
- R8: `a_disp` and `b_disp` are always complementary.
- R9: Reset (`rst_n`=0, asynchronous) gives `a_disp`=1, `b_disp`=0, `sep_n`=1, `ch1_sel`=1. `ch1_sel` is also held at 1 whenever the mode is not 2'b10 or `dual_alt`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hmode | input | 2 | Horizontal mode: 00 A, 01 B, 10 alternate, 11 as A |
| dual_alt | input | 1 | Vertical system alternates between two channels |
| alt_sync | input | 1 | End-of-sweep line; a fall marks the end of a sweep |
| a_disp | output | 1 | A sweep routed to the horizontal channel |
| b_disp | output | 1 | B sweep routed to the horizontal channel |
| sep_n | output | 1 | Active-low A/B separation enable |
| ch1_sel | output | 1 | Channel-select toggle, 1 = channel 1 |

## Verification
The assertions assume that `alt_sync` is already synchronous to `clk`. They also assume that an end of sweep is defined only by two consecutive samples, so a pulse shorter than one clock goes unseen. The bench changes every input only on the falling clock edge, and it holds each level of `alt_sync` for at least one full cycle. It also tests the case where a mode change and a fall of `alt_sync` arrive at the same edge. In that case, the entry rule is the one expected to win.

// File: rtl/sweep_sel_pkg.sv
package sweep_sel_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    HM_MAIN  = 2'b00,
    HM_DELAY = 2'b01,
    HM_ALT   = 2'b10,
    HM_SPARE = 2'b11
  } hmode_t;

  function automatic logic mode_is_alt(input logic [MODE_W-1:0] m);
    return m == HM_ALT;
  endfunction

  function automatic logic mode_holds_b(input logic [MODE_W-1:0] m);
    return m == HM_DELAY;
  endfunction

  // Channel bit after an end-of-sweep event
  function automatic logic chan_next(input logic ch1, input logic ev);
    return ev ? ~ch1 : ch1;
  endfunction

  // Selection after an advance request
  function automatic logic sel_next(input logic sel, input logic adv);
    return adv ? ~sel : sel;
  endfunction
endpackage

// File: rtl/alt_sync_edge.sv
module alt_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic fall_ev
);
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign fall_ev = sync_q & ~sync_in;
endmodule

// File: rtl/chan_toggle.sv
module chan_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic eos,
  output logic ch1_q,
  output logic ch_rise
);
  import sweep_sel_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ch1_q <= 1'b1;
    else if (hold) ch1_q <= 1'b1;
    else           ch1_q <= chan_next(ch1_q, eos);
  end

  // Return to channel 1 at this edge
  assign ch_rise = ~hold & eos & ~ch1_q;
endmodule

// File: rtl/sweep_select_ff.sv
module sweep_select_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_mode,
  input  logic force_b,
  input  logic alt_entry,
  input  logic advance,
  output logic sel_b_q
);
  import sweep_sel_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_b_q <= 1'b0;
    else if (!alt_mode) sel_b_q <= force_b;
    else if (alt_entry) sel_b_q <= 1'b0;
    else                sel_b_q <= sel_next(sel_b_q, advance);
  end
endmodule

// File: rtl/alt_sweep_selector.sv
module alt_sweep_selector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hmode,
  input  logic       dual_alt,
  input  logic       alt_sync,
  output logic       a_disp,
  output logic       b_disp,
  output logic       sep_n,
  output logic       ch1_sel
);
  import sweep_sel_pkg::*;

  logic alt_now, alt_q, alt_entry_w, eos_w, ch_rise_w, sel_b_w, adv_w, ch_hold_w;

  assign alt_now     = mode_is_alt(hmode);
  assign alt_entry_w = alt_now & ~alt_q;
  assign ch_hold_w   = ~alt_now | ~dual_alt | alt_entry_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alt_q <= 1'b0;
    else        alt_q <= alt_now;
  end

  alt_sync_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sync_in(alt_sync), .fall_ev(eos_w)
  );

  chan_toggle u_chan (
    .clk(clk), .rst_n(rst_n), .hold(ch_hold_w), .eos(eos_w),
    .ch1_q(ch1_sel), .ch_rise(ch_rise_w)
  );

  assign adv_w = dual_alt ? ch_rise_w : eos_w;

  sweep_select_ff u_sel (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_now), .force_b(mode_holds_b(hmode)),
    .alt_entry(alt_entry_w), .advance(adv_w), .sel_b_q(sel_b_w)
  );

  assign b_disp = sel_b_w;
  assign a_disp = ~sel_b_w;
  assign sep_n  = ~(alt_q & sel_b_w);
endmodule

// File: rtl/alt_sweep_selector_chk.sv
module alt_sweep_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] hmode,
  input logic       dual_alt,
  input logic       a_disp,
  input logic       b_disp,
  input logic       sep_n,
  input logic       ch1_sel,
  input logic       eos,
  input logic       alt_entry
);
  logic run_alt;
  assign run_alt = (hmode == 2'b10) && !alt_entry;

  assert_hold_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hmode == 2'b00 || hmode == 2'b11) |=> a_disp);
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hmode == 2'b01) |=> (b_disp && sep_n));
  assert_alt_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_alt && !dual_alt && eos) |=> (b_disp != $past(b_disp)));
  assert_chan_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_alt && dual_alt && eos) |=> (ch1_sel != $past(ch1_sel)));
  assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_alt && dual_alt && (!eos || ch1_sel)) |=> $stable(b_disp));
  assert_sep_only_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sep_n |-> b_disp);
  assert_entry_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alt_entry |=> (a_disp && ch1_sel));
  assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a_disp != b_disp);
  assert_chan_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hmode != 2'b10 || !dual_alt) |=> ch1_sel);
endmodule

bind alt_sweep_selector alt_sweep_selector_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hmode(hmode), .dual_alt(dual_alt),
  .a_disp(a_disp), .b_disp(b_disp), .sep_n(sep_n), .ch1_sel(ch1_sel),
  .eos(eos_w), .alt_entry(alt_entry_w)
);

// File: tb/alt_sweep_selector_tb_top.sv
`timescale 1ns/1ps
module alt_sweep_selector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] hmode = 2'b00;
  logic dual_alt = 1'b0;
  logic alt_sync = 1'b0;
  logic a_disp, b_disp, sep_n, ch1_sel;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alt_sweep_selector dut_i (
    .clk(clk), .rst_n(rst_n), .hmode(hmode), .dual_alt(dual_alt), .alt_sync(alt_sync),
    .a_disp(a_disp), .b_disp(b_disp), .sep_n(sep_n), .ch1_sel(ch1_sel)
  );

  // {hmode, dual_alt, alt_sync, a_disp, b_disp, sep_n, ch1_sel}
  localparam int NV = 24;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_0_0_1011,  // R1 main held
    8'b01_0_0_0111,  // R2 delayed held
    8'b01_0_1_0111,  // R2
    8'b01_0_0_0111,  // R2 fall ignored
    8'b10_0_1_1011,  // R7 entry from B
    8'b10_0_0_0101,  // R3 eos -> B, R6 sep low
    8'b10_0_1_0101,  // R3
    8'b10_0_0_1011,  // R3 eos -> A
    8'b10_0_1_1011,  // R3
    8'b10_1_0_1010,  // R4 ch2, R5 A stays
    8'b10_1_1_1010,  // R5
    8'b10_1_0_0101,  // R5 ch1 rise -> B ch1
    8'b10_1_1_0101,  // R5
    8'b10_1_0_0100,  // R4 B ch2
    8'b10_1_1_0100,  // R5
    8'b10_1_0_1011,  // R5 back to A ch1
    8'b10_1_0_1011,  // R3 held low, no event
    8'b11_1_1_1011,  // R1 spare code as main
    8'b10_1_0_1011,  // R7 entry beats coincident eos
    8'b10_1_1_1011,  // R7
    8'b10_1_0_1010,  // R4
    8'b10_0_1_1011,  // R9 channel forced to 1
    8'b01_1_0_0111,  // R2 R9
    8'b10_1_1_1011   // R7
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got a/b/sep_n/ch1=%b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {a_disp, b_disp, sep_n, ch1_sel}, 4'b1011);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {hmode, dual_alt, alt_sync} = VEC[i][7:4];
      @(negedge clk);
      check($sformatf("vector %0d (R1..R9)", i), {a_disp, b_disp, sep_n, ch1_sel}, VEC[i][3:0]);
    end
    // Directed: walk two full dual-channel cycles, R5 order
    begin
      logic [3:0] order [4] = '{4'b1011, 4'b1010, 4'b0101, 4'b0100};
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); alt_sync = 1'b0;
        @(negedge clk);
        check("R5 order", {a_disp, b_disp, sep_n, ch1_sel}, order[(k + 1) % 4]);
        alt_sync = 1'b1;
      end
    end
    // Directed: reset in the middle of a B display, R9
    @(negedge clk); alt_sync = 1'b0; dual_alt = 1'b0;
    @(negedge clk);
    check("R3 pre-reset", {a_disp, b_disp, sep_n, ch1_sel}, 4'b0101);
    #1 rst_n = 1'b0;
    #1 check("R9 async reset", {a_disp, b_disp, sep_n, ch1_sel}, 4'b1011);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {a_disp, b_disp, sep_n, ch1_sel}, 4'b1011);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule